// File: doc/BRIEF.md
# External Interrupt Input Controller

This block samples a small set of asynchronous interrupt pins that enter the chip from outside. Each pin is synchronized to the local clock. A per-pin trigger code chooses what counts as an event: a rising edge, a falling edge, either edge, a high level, a low level, or nothing. An event latches a pending flag for that pin. Each pending flag is gated by its own enable bit. The gated flags are exposed as a per-pin request vector and are also ORed into one interrupt line for the upstream interrupt controller.

Software reaches the block through a single-cycle strobe port with four word registers:

- trigger configuration at 0x00
- pending status at 0x04 (read-only)
- pending clear at 0x08 (write-only, active-low bits)
- enable at 0x0C

The usual bring-up sequence is:

1. Select a trigger code, typically active-low level.
2. Clear the pin's pending bit.
3. Set its enable bit.

Top module: `xirq_unit`

## Requirements
- R1: After a synchronous reset the configuration, pending and enable state are all zero, `irq_o` and `irq_vec_o` are low, and `rdata_o` is zero.
- R2: Register 0x00 holds the trigger codes, with pin i using bits [4i+3:4i]. Writes store only the low 4·N_IN bits, and reading it back returns them with zeros above.
- R3: Code 1 (rising) sets pending on a 0→1 change of the pin. The pending bit becomes visible after the third rising clock edge that follows the pin change. It stays set with no further event until cleared.
- R4: Code 2 (falling) sets pending on a 1→0 change of the pin, and a 0→1 change sets nothing.
- R5: Code 3 (both) sets pending on either change of the pin.
- R6: Code 5 (high) and code 6 (low) set pending on every cycle the synchronized pin is at the active level. A clear issued while the level is active has no effect. After the level goes away, pending holds until cleared.
- R7: Codes 0, 4 and 7 to 15 never set pending, whatever the pin does.
- R8: A write to 0x08 clears pending bit i where data bit i is 0, and leaves it where data bit i is 1. An event in the same cycle as a clear wins. Writes to 0x04 change nothing.
- R9: Bit i of register 0x0C enables pin i. `irq_vec_o` equals pending AND enable, and `irq_o` is the OR of `irq_vec_o`.
- R10: A read strobe returns data on `rdata_o` one cycle later. Offset 0x04 gives pending and 0x0C gives enable. Offset 0x08 and every unmapped offset read as zero, and `rdata_o` is zero in any cycle after no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | N_IN | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| irq_vec_o | output | N_IN | Per-pin request, pending AND enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The embedded properties assume that the pins reach the detector only through the synchronizer. They also assume that write and read strobes are never both raised for the same offset in a way that relies on ordering. The bench drives pins and strobes only on the falling clock edge, so every input is settled before the sampling edge. It raises at most one strobe per cycle, which keeps the stimulus inside those assumptions. The behavioural model tracks each pin's sampled history and pending state, and the bench compares the request vector, the combined line and the read data with it on every cycle.

// File: rtl/xirq_pkg.sv
// Package: shared trigger codes and register offsets for the external interrupt controller.
// Assumes byte offsets on a word-aligned register port.
package xirq_pkg;

    typedef enum logic [3:0] {
        TRIG_OFF  = 4'd0,
        TRIG_RISE = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_BOTH = 4'd3,
        TRIG_HIGH = 4'd5,
        TRIG_LOW  = 4'd6
    } trig_e;

    localparam int TRIG_FIELD_W = 4;

    localparam int OFS_TRIG = 'h0;
    localparam int OFS_PEND = 'h4;
    localparam int OFS_CLR  = 'h8;
    localparam int OFS_EN   = 'hC;

endpackage

// File: rtl/xirq_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous pins.
// Assumes each pin is a slow, independent signal; no bus coherence is implied.
module xirq_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Purpose: move the pins into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/xirq_detect.sv
// Module: trigger detection and pending flag for one synchronized pin.
// Assumes lvl_i is already synchronous; clr_i is a one-cycle clear request.
module xirq_detect
    import xirq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lvl_i,
    input  logic [TRIG_FIELD_W-1:0] mode_i,
    input  logic                    clr_i,
    output logic                    pend_o
);

    logic prev_q;
    logic pend_q;
    logic rise;
    logic fall;
    logic evt;

    // Purpose: derive edge flags and select the event for the configured code.
    always_comb begin
        rise = lvl_i & ~prev_q;
        fall = ~lvl_i & prev_q;
        case (mode_i)
            TRIG_RISE: evt = rise;
            TRIG_FALL: evt = fall;
            TRIG_BOTH: evt = rise | fall;
            TRIG_HIGH: evt = lvl_i;
            TRIG_LOW:  evt = ~lvl_i;
            default:   evt = 1'b0;
        endcase
    end

    // Purpose: remember last level and latch pending; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            pend_q <= evt | (pend_q & ~clr_i);
        end
    end

    assign pend_o = pend_q;

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i inside {TRIG_RISE, TRIG_FALL, TRIG_BOTH}) && pend_q && !clr_i) |=> pend_q);

    assert_high_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_HIGH && lvl_i) |=> pend_q);

    assert_bad_code_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mode_i inside {TRIG_RISE, TRIG_FALL, TRIG_BOTH, TRIG_HIGH, TRIG_LOW}) && !pend_q) |=> !pend_q);

endmodule

// File: rtl/xirq_regs.sv
// Module: register decode for trigger codes, enable, pending clear and readback.
// Assumes single-cycle strobes and byte offsets; rdata is registered.
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic                   rd_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [N_IN-1:0]        pend_i,
    output logic [TRIG_FIELD_W*N_IN-1:0] cfg_o,
    output logic [N_IN-1:0]        en_o,
    output logic [N_IN-1:0]        clr_o,
    output logic [DATA_W-1:0]      rdata_o
);

    localparam int CFG_W = TRIG_FIELD_W * N_IN;
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);

    logic [CFG_W-1:0]  cfg_q;
    logic [N_IN-1:0]   en_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;

    // Purpose: clear request per pin, active where the written bit is zero.
    always_comb begin
        clr_o = '0;
        if (wr_en_i && addr_i == A_CLR)
            clr_o = ~wdata_i[N_IN-1:0];
    end

    // Purpose: select readback data; write-only and unmapped offsets give zero.
    always_comb begin
        case (addr_i)
            A_TRIG:  rd_mux = DATA_W'(cfg_q);
            A_PEND:  rd_mux = DATA_W'(pend_i);
            A_EN:    rd_mux = DATA_W'(en_q);
            default: rd_mux = '0;
        endcase
    end

    // Purpose: store configuration and enable, register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            en_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_en_i && addr_i == A_TRIG)
                cfg_q <= wdata_i[CFG_W-1:0];
            if (wr_en_i && addr_i == A_EN)
                en_q <= wdata_i[N_IN-1:0];
            rdata_q <= rd_en_i ? rd_mux : '0;
        end
    end

    assign cfg_o   = cfg_q;
    assign en_o    = en_q;
    assign rdata_o = rdata_q;

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_TRIG) |=> (cfg_o == $past(wdata_i[CFG_W-1:0])));

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == '0));

endmodule

// File: rtl/xirq_unit.sv
// Module: top of the external interrupt controller; synchronizes the pins, runs one
// detector per pin and combines enabled pending flags into the request outputs.
// Assumes N_IN*4 <= DATA_W and register offsets fit in ADDR_W bits.
module xirq_unit
    import xirq_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   pin_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_IN-1:0]   irq_vec_o,
    output logic              irq_o
);

    localparam int CFG_W = TRIG_FIELD_W * N_IN;
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(OFS_EN);

    logic [N_IN-1:0]  lvl;
    logic [N_IN-1:0]  pend;
    logic [N_IN-1:0]  en;
    logic [N_IN-1:0]  clr;
    logic [CFG_W-1:0] cfg;

    xirq_sync #(.WIDTH(N_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (lvl)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_pin
        xirq_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl[g]),
            .mode_i (cfg[g*TRIG_FIELD_W +: TRIG_FIELD_W]),
            .clr_i  (clr[g]),
            .pend_o (pend[g])
        );
    end

    xirq_regs #(.N_IN(N_IN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend),
        .cfg_o   (cfg),
        .en_o    (en),
        .clr_o   (clr),
        .rdata_o (rdata_o)
    );

    // Purpose: gate pending by enable and merge into one request line.
    always_comb begin
        irq_vec_o = pend & en;
        irq_o     = |irq_vec_o;
    end

    assert_en_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_EN && wdata_i[N_IN-1:0] == '0) |=> !irq_o);

endmodule

// File: tb/sim_xirq_unit.sv
module sim_xirq_unit;

    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] irq_vec;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xirq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_vec_o(irq_vec), .irq_o(irq)
    );

    // reference model state
    bit [N-1:0]   h1, h2, h3;   // pin samples one, two and three edges back
    bit [N-1:0]   m_pend, m_en;
    bit [4*N-1:0] m_cfg;
    bit [31:0]    m_rd;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0; h3 = '0;
            m_pend = '0; m_en = '0; m_cfg = '0; m_rd = '0;
        end else begin
            bit [N-1:0] nxt;
            for (int i = 0; i < N; i++) begin
                int code;
                bit ev;
                bit cl;
                code = int'(m_cfg[4*i +: 4]);
                ev = 0;
                if (code == 1) ev = h2[i] && !h3[i];
                else if (code == 2) ev = !h2[i] && h3[i];
                else if (code == 3) ev = h2[i] != h3[i];
                else if (code == 5) ev = h2[i];
                else if (code == 6) ev = !h2[i];
                cl = wr_en && addr == 4'h8 && !wdata[i];
                nxt[i] = ev || (m_pend[i] && !cl);
            end
            if (rd_en) begin
                if (addr == 4'h0) m_rd = 32'(m_cfg);
                else if (addr == 4'h4) m_rd = 32'(m_pend);
                else if (addr == 4'hC) m_rd = 32'(m_en);
                else m_rd = 0;
            end else m_rd = 0;
            if (wr_en && addr == 4'h0) m_cfg = wdata[4*N-1:0];
            if (wr_en && addr == 4'hC) m_en = wdata[N-1:0];
            m_pend = nxt;
            h3 = h2; h2 = h1; h1 = pins;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(irq_vec == (m_pend & m_en), "R9 irq_vec", irq_vec, m_pend & m_en);
            chk(irq == |(m_pend & m_en), "R9 irq", irq, |(m_pend & m_en));
            chk(rdata == m_rd, "R10 rdata", rdata, m_rd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = '0;
    endtask

    task automatic rd_hand(input logic [3:0] a, input logic [31:0] mask, input logic [31:0] val, input string tag);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
        chk((rdata & mask) == val, tag, rdata & mask, val);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1;
        // R1: reset state
        chk(irq == 0, "R1 irq", irq, 0);
        chk(irq_vec == 0, "R1 irq_vec", irq_vec, 0);
        chk(rdata == 0, "R1 rdata", rdata, 0);
        live = 1;
        rd_hand(4'h0, 32'hFFFF_FFFF, 0, "R1 cfg");
        rd_hand(4'h4, 32'hFFFF_FFFF, 0, "R1 pend");
        rd_hand(4'hC, 32'hFFFF_FFFF, 0, "R1 en");

        // R2: trigger fields, upper bits dropped
        pins = 6'b010010;
        wr(4'h0, 32'hFF76_5321);
        rd_hand(4'h0, 32'hFFFF_FFFF, 32'h0076_5321, "R2 cfg readback");
        cyc(5);
        wr(4'h8, 0);
        wr(4'hC, 32'h3F);
        rd_hand(4'hC, 32'hFFFF_FFFF, 32'h3F, "R10 enable read");
        rd_hand(4'h4, 32'h3F, 0, "R8 pending after clear");

        // R3: rising latency and hold
        pins[0] = 1;
        cyc(2);
        chk(irq_vec[0] == 0, "R3 before third edge", irq_vec[0], 0);
        cyc(1);
        chk(irq_vec[0] == 1, "R3 after third edge", irq_vec[0], 1);
        cyc(5);
        rd_hand(4'h4, 32'h1, 32'h1, "R3 hold");

        // R4: falling only
        wr(4'h8, 0);
        pins[1] = 0; cyc(4);
        rd_hand(4'h4, 32'h2, 32'h2, "R4 fall sets");
        wr(4'h8, 0);
        pins[1] = 1; cyc(4);
        rd_hand(4'h4, 32'h2, 32'h0, "R4 rise ignored");

        // R5: both edges
        wr(4'h8, 0);
        pins[2] = 1; cyc(4);
        rd_hand(4'h4, 32'h4, 32'h4, "R5 rise");
        wr(4'h8, 0);
        pins[2] = 0; cyc(4);
        rd_hand(4'h4, 32'h4, 32'h4, "R5 fall");

        // R6: level modes
        pins[3] = 1; cyc(4);
        wr(4'h8, 0);
        rd_hand(4'h4, 32'h8, 32'h8, "R6 clear while high");
        pins[3] = 0; cyc(4);
        rd_hand(4'h4, 32'h8, 32'h8, "R6 hold after level");
        wr(4'h8, 0);
        rd_hand(4'h4, 32'h8, 32'h0, "R6 clear after level");
        pins[4] = 0; cyc(4);
        rd_hand(4'h4, 32'h10, 32'h10, "R6 active low");
        pins[4] = 1; cyc(4);

        // R7: invalid and disabled codes
        for (int c = 0; c < 16; c++) begin
            if (c inside {0, 4, 7, 8, 9, 10, 11, 12, 13, 14, 15}) begin
                wr(4'h0, 32'h0006_5321 | (32'(c) << 20));
                wr(4'h8, 0);
                pins[5] = ~pins[5]; cyc(4);
                pins[5] = ~pins[5]; cyc(4);
                rd_hand(4'h4, 32'h20, 32'h0, "R7 code quiet");
            end
        end

        // R8: same-cycle event beats clear, ones keep, status write ignored
        pins[0] = 0; cyc(4);
        wr(4'h8, 0);
        pins[0] = 1;
        cyc(2);
        wr(4'h8, 0);
        rd_hand(4'h4, 32'h1, 32'h1, "R8 event wins");
        wr(4'h8, 32'h3F);
        rd_hand(4'h4, 32'h1, 32'h1, "R8 ones keep");
        wr(4'h8, 0);
        wr(4'h4, 32'h3F);
        rd_hand(4'h4, 32'h3F, 32'h0, "R8 status write ignored");

        // R9: enable gating
        pins[2] = 1; pins[0] = 0; cyc(4);
        pins[0] = 1; cyc(4);
        wr(4'hC, 32'h4);
        chk(irq_vec == 6'h04, "R9 mask one", irq_vec, 6'h04);
        chk(irq == 1, "R9 irq on", irq, 1);
        wr(4'hC, 0);
        chk(irq == 0, "R9 irq off", irq, 0);

        // R10: write-only and unmapped offsets
        rd_hand(4'h8, 32'hFFFF_FFFF, 0, "R10 clear reads zero");
        rd_hand(4'hE, 32'hFFFF_FFFF, 0, "R10 unmapped 0xE");
        rd_hand(4'h1, 32'hFFFF_FFFF, 0, "R10 unmapped 0x1");
        cyc(1);
        chk(rdata == 0, "R10 idle zero", rdata, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule